// File: doc/BRIEF.md
# Timer Event Flag Register Unit

This block holds the status flags of an eight-channel capture/compare timer with a 16-bit free-running counter. Each channel raises a sticky flag when its capture or compare event fires. A separate overflow flag is raised when the counter wraps. Each flag is ANDed with its own enable to drive a registered interrupt request. Software reads the flags over a byte-wide register bus and clears them by writing ones.

An optional fast-clear mode removes the need for a separate clearing write. In this mode a flag is cleared as a side effect of the access software makes anyway. For an input-capture channel that access is a read of the channel's data bytes. For an output-compare channel it is a write to those bytes. For the overflow flag it is any access to the counter. The counter, the capture latches, compare matching and the pins live elsewhere. They reach this block only as event pulses and mode bits.

Top module: `tmr_flag_unit`

## Requirements
- R1: A high `ch_evt[n]` in a cycle sets channel flag n at that clock edge. Channel flags read back at offset 0x0E, with channel n in bit n.
- R2: A write to offset 0x0E clears every channel flag whose data bit is one and leaves the flags whose data bit is zero unchanged.
- R3: When a set event and any kind of clear hit the same flag in the same cycle, the flag ends up set.
- R4: With `fast_clr_en` high and `ch_is_oc[n]` low (input capture), a read of offset 0x10+2n or 0x11+2n clears channel flag n. A write to those offsets does not clear it.
- R5: With `fast_clr_en` high and `ch_is_oc[n]` high (output compare), a write to offset 0x10+2n or 0x11+2n clears channel flag n. A read of those offsets does not clear it.
- R6: With `fast_clr_en` low, accesses to the channel data offsets leave every flag unchanged.
- R7: A high `ovf_evt` sets the overflow flag, which reads back as bit 7 of offset 0x0F. Bits 6..0 of that offset always read zero, and writing them has no effect.
- R8: A write to offset 0x0F with data bit 7 set clears the overflow flag.
- R9: With `fast_clr_en` high, a read or a write of offset 0x04 or 0x05 clears the overflow flag. With `fast_clr_en` low, such accesses leave it set.
- R10: After reset, both flag offsets read 0x00 and every interrupt output is low.
- R11: `ch_irq[n]` and `ovf_irq` are registered. Each is high one cycle after the matching flag and its enable are both high, and stays high for as long as both stay high.
- R12: `rdata` is registered on a cycle with `rd_en` high. It returns the flag values from before any clear made in that same cycle. Offsets other than 0x0E and 0x0F read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Register byte offset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| ch_evt | input | 8 | Per-channel capture/compare event pulses |
| ovf_evt | input | 1 | Counter wrap pulse |
| fast_clr_en | input | 1 | Fast-clear mode enable |
| ch_is_oc | input | 8 | Channel mode: 1 output compare, 0 input capture |
| ch_ie | input | 8 | Per-channel interrupt enables |
| ovf_ie | input | 1 | Overflow interrupt enable |
| ch_irq | output | 8 | Per-channel interrupt requests |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
A wrong flag state shows up in two places at the ports. It appears on the interrupt outputs one clock after the bad edge whenever the matching enable is high. It also appears in `rdata` on the first later read of offset 0x0E or 0x0F. The stimulus sets flags and then probes each clear path, in both directions of channel mode and with fast-clear on and off. It then reads the flag bytes back right away. Any clear taken from the wrong channel, the wrong access direction or the wrong decode is therefore exposed within two cycles.

// File: rtl/tfu_pkg.sv
package tfu_pkg;
  localparam int CNT_LO_OFS  = 'h04;
  localparam int CNT_HI_OFS  = 'h05;
  localparam int CHFLAG_OFS  = 'h0E;
  localparam int OVFFLAG_OFS = 'h0F;
  localparam int CHDATA_BASE = 'h10;
  localparam int CHDATA_STEP = 2;
endpackage

// File: rtl/tfu_decode.sv
module tfu_decode #(
  parameter int NCH    = 8,
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NCH-1:0]    ch_hit,
  output logic              chflag_hit,
  output logic              ovfflag_hit,
  output logic              cnt_hit
);
  import tfu_pkg::*;

  localparam logic [ADDR_W-1:0] PAIR_MASK = ~ADDR_W'(1);

  assign chflag_hit  = (addr == ADDR_W'(CHFLAG_OFS));
  assign ovfflag_hit = (addr == ADDR_W'(OVFFLAG_OFS));
  assign cnt_hit     = (addr == ADDR_W'(CNT_LO_OFS)) || (addr == ADDR_W'(CNT_HI_OFS));

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    localparam logic [ADDR_W-1:0] HI_OFS = ADDR_W'(CHDATA_BASE + CHDATA_STEP * n);
    assign ch_hit[n] = ((addr & PAIR_MASK) == HI_OFS);
  end
endmodule

// File: rtl/tfu_flag_cell.sv
module tfu_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (rst) flag_o <= 1'b0;
    else     flag_o <= set_i | (flag_o & ~clr_i);
  end
endmodule

// File: rtl/tfu_readback.sv
module tfu_readback #(
  parameter int NCH    = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              chflag_hit,
  input  logic              ovfflag_hit,
  input  logic [NCH-1:0]    ch_flag,
  input  logic              ovf_flag,
  output logic [DATA_W-1:0] rdata
);
  localparam int OVF_BIT = DATA_W - 1;

  logic [DATA_W-1:0] sel;

  always_comb begin
    sel = '0;
    if (chflag_hit)  sel = DATA_W'(ch_flag);
    if (ovfflag_hit) sel[OVF_BIT] = ovf_flag;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= sel;
  end
endmodule

// File: rtl/tmr_flag_unit.sv
module tmr_flag_unit #(
  parameter int NCH    = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [NCH-1:0]    ch_evt,
  input  logic              ovf_evt,
  input  logic              fast_clr_en,
  input  logic [NCH-1:0]    ch_is_oc,
  input  logic [NCH-1:0]    ch_ie,
  input  logic              ovf_ie,
  output logic [NCH-1:0]    ch_irq,
  output logic              ovf_irq
);
  localparam int OVF_BIT = DATA_W - 1;

  logic [NCH-1:0] ch_hit;
  logic           chflag_hit, ovfflag_hit, cnt_hit;
  logic [NCH-1:0] ch_clr;
  logic [NCH-1:0] ch_flag_q;
  logic           ovf_clr, ovf_flag_q;

  tfu_decode #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dec (
    .addr        (addr),
    .ch_hit      (ch_hit),
    .chflag_hit  (chflag_hit),
    .ovfflag_hit (ovfflag_hit),
    .cnt_hit     (cnt_hit)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_flag
    logic w1c, fast;
    assign w1c  = wr_en & chflag_hit & wdata[n];
    assign fast = fast_clr_en & ch_hit[n] & (ch_is_oc[n] ? wr_en : rd_en);
    assign ch_clr[n] = w1c | fast;

    tfu_flag_cell u_cell (
      .clk    (clk),
      .rst    (rst),
      .set_i  (ch_evt[n]),
      .clr_i  (ch_clr[n]),
      .flag_o (ch_flag_q[n])
    );
  end

  assign ovf_clr = (wr_en & ovfflag_hit & wdata[OVF_BIT])
                 | (fast_clr_en & cnt_hit & (rd_en | wr_en));

  tfu_flag_cell u_ovf (
    .clk    (clk),
    .rst    (rst),
    .set_i  (ovf_evt),
    .clr_i  (ovf_clr),
    .flag_o (ovf_flag_q)
  );

  tfu_readback #(.NCH(NCH), .DATA_W(DATA_W)) u_rb (
    .clk         (clk),
    .rst         (rst),
    .rd_en       (rd_en),
    .chflag_hit  (chflag_hit),
    .ovfflag_hit (ovfflag_hit),
    .ch_flag     (ch_flag_q),
    .ovf_flag    (ovf_flag_q),
    .rdata       (rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ch_irq  <= '0;
      ovf_irq <= 1'b0;
    end else begin
      ch_irq  <= ch_flag_q & ch_ie;
      ovf_irq <= ovf_flag_q & ovf_ie;
    end
  end
endmodule

// File: rtl/tfu_checker.sv
module tfu_checker #(
  parameter int NCH    = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              rd_en,
  input logic              wr_en,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic [NCH-1:0]    ch_evt,
  input logic              ovf_evt,
  input logic              fast_clr_en,
  input logic [NCH-1:0]    ch_flag,
  input logic              ovf_flag,
  input logic [NCH-1:0]    ch_ie,
  input logic              ovf_ie,
  input logic [NCH-1:0]    ch_irq,
  input logic              ovf_irq
);
  import tfu_pkg::*;

  AST_CH_SET: assert property (@(posedge clk) disable iff (rst)
    (ch_evt != '0) |=> ((ch_flag & $past(ch_evt)) == $past(ch_evt))); // R1

  AST_W1C: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(CHFLAG_OFS) && ch_evt == '0)
      |=> ((ch_flag & $past(wdata[NCH-1:0])) == '0)); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!rd_en && !wr_en && ch_evt == '0 && !ovf_evt)
      |=> ($stable(ch_flag) && $stable(ovf_flag))); // R6

  AST_OVF_SET: assert property (@(posedge clk) disable iff (rst)
    ovf_evt |=> ovf_flag); // R7

  AST_UNIMP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(OVFFLAG_OFS)) |=> (rdata[DATA_W-2:0] == '0)); // R7

  AST_FAST_OVF: assert property (@(posedge clk) disable iff (rst)
    (fast_clr_en && (rd_en || wr_en) && !ovf_evt &&
     (addr == ADDR_W'(CNT_LO_OFS) || addr == ADDR_W'(CNT_HI_OFS))) |=> !ovf_flag); // R9

  AST_CH_IRQ_MASK: assert property (@(posedge clk) disable iff (rst)
    (ch_ie == '0) |=> (ch_irq == '0)); // R11

  AST_OVF_IRQ_MASK: assert property (@(posedge clk) disable iff (rst)
    !ovf_ie |=> !ovf_irq); // R11
endmodule

bind tmr_flag_unit tfu_checker #(.NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .addr        (addr),
  .rd_en       (rd_en),
  .wr_en       (wr_en),
  .wdata       (wdata),
  .rdata       (rdata),
  .ch_evt      (ch_evt),
  .ovf_evt     (ovf_evt),
  .fast_clr_en (fast_clr_en),
  .ch_flag     (ch_flag_q),
  .ovf_flag    (ovf_flag_q),
  .ch_ie       (ch_ie),
  .ovf_ie      (ovf_ie),
  .ch_irq      (ch_irq),
  .ovf_irq     (ovf_irq)
);

// File: tb/tmr_flag_unit_tb_top.sv
`timescale 1ns/1ps
module tmr_flag_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] addr = '0;
  logic       rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] ch_evt = '0;
  logic       ovf_evt = 1'b0, fast_clr_en = 1'b0;
  logic [7:0] ch_is_oc = '0, ch_ie = '0;
  logic       ovf_ie = 1'b0;
  logic [7:0] ch_irq;
  logic       ovf_irq;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  tmr_flag_unit dut_i (
    .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .ch_evt(ch_evt), .ovf_evt(ovf_evt),
    .fast_clr_en(fast_clr_en), .ch_is_oc(ch_is_oc), .ch_ie(ch_ie),
    .ovf_ie(ovf_ie), .ch_irq(ch_irq), .ovf_irq(ovf_irq)
  );

  // {cmd(1=rd,2=wr), addr, wdata, evt, ovf, fast, oc, check_addr, expected}
  localparam int NV = 21;
  localparam logic [51:0] VEC [NV] = '{
    {2'd0, 8'h00, 8'h00, 8'h05, 1'b0, 1'b0, 8'h00, 8'h0E, 8'h05}, // R1
    {2'd2, 8'h0E, 8'h01, 8'h00, 1'b0, 1'b0, 8'h00, 8'h0E, 8'h04}, // R2
    {2'd2, 8'h0E, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 8'h0E, 8'h04}, // R2
    {2'd2, 8'h0E, 8'h84, 8'h80, 1'b0, 1'b0, 8'h00, 8'h0E, 8'h80}, // R3
    {2'd1, 8'h1E, 8'h00, 8'h00, 1'b0, 1'b1, 8'h00, 8'h0E, 8'h00}, // R4
    {2'd0, 8'h00, 8'h00, 8'h02, 1'b0, 1'b0, 8'h00, 8'h0E, 8'h02}, // R1
    {2'd2, 8'h13, 8'hAA, 8'h00, 1'b0, 1'b1, 8'h00, 8'h0E, 8'h02}, // R4
    {2'd2, 8'h12, 8'h55, 8'h00, 1'b0, 1'b1, 8'h02, 8'h0E, 8'h00}, // R5
    {2'd0, 8'h00, 8'h00, 8'h08, 1'b0, 1'b0, 8'h00, 8'h0E, 8'h08}, // R1
    {2'd1, 8'h16, 8'h00, 8'h00, 1'b0, 1'b1, 8'h08, 8'h0E, 8'h08}, // R5
    {2'd1, 8'h17, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 8'h0E, 8'h08}, // R6
    {2'd2, 8'h16, 8'hFF, 8'h00, 1'b0, 1'b0, 8'hFF, 8'h0E, 8'h08}, // R6
    {2'd0, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 8'h00, 8'h0F, 8'h80}, // R7
    {2'd2, 8'h0F, 8'h7F, 8'h00, 1'b0, 1'b0, 8'h00, 8'h0F, 8'h80}, // R7
    {2'd2, 8'h0F, 8'h80, 8'h00, 1'b0, 1'b0, 8'h00, 8'h0F, 8'h00}, // R8
    {2'd0, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 8'h00, 8'h0F, 8'h80}, // R7
    {2'd1, 8'h04, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 8'h0F, 8'h80}, // R9
    {2'd1, 8'h05, 8'h00, 8'h00, 1'b0, 1'b1, 8'h00, 8'h0F, 8'h00}, // R9
    {2'd0, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 8'h00, 8'h0F, 8'h80}, // R7
    {2'd2, 8'h04, 8'h00, 8'h00, 1'b0, 1'b1, 8'h00, 8'h0F, 8'h00}, // R9
    {2'd1, 8'h18, 8'h00, 8'h10, 1'b0, 1'b1, 8'h00, 8'h0E, 8'h18}  // R3
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic read_reg(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1; wr_en = 1'b0; fast_clr_en = 1'b0;
    @(posedge clk); #1;
    d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic apply(input logic [51:0] v);
    @(negedge clk);
    rd_en       = (v[51:50] == 2'd1);
    wr_en       = (v[51:50] == 2'd2);
    addr        = v[49:42];
    wdata       = v[41:34];
    ch_evt      = v[33:26];
    ovf_evt     = v[25];
    fast_clr_en = v[24];
    ch_is_oc    = v[23:16];
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0; ch_evt = '0; ovf_evt = 1'b0;
    fast_clr_en = 1'b0; ch_is_oc = '0;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R10 reset state
    read_reg(8'h0E, d); check("R10 chflag", d, 8'h00);
    read_reg(8'h0F, d); check("R10 ovfflag", d, 8'h00);
    check("R10 irq", {ch_irq[6:0], ovf_irq}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      read_reg(VEC[i][15:8], d);
      check($sformatf("vector %0d (see table tag)", i), d, VEC[i][7:0]);
    end

    // R12: read and clear in the same cycle return the old value; other offsets read 0
    @(negedge clk);
    addr = 8'h0E; rd_en = 1'b1; wr_en = 1'b1; wdata = 8'h10;
    @(posedge clk); #1;
    check("R12 pre-clear", rdata, 8'h18);
    @(negedge clk); rd_en = 1'b0; wr_en = 1'b0;
    read_reg(8'h0E, d); check("R12 after clear", d, 8'h08);
    read_reg(8'h20, d); check("R12 unmapped", d, 8'h00);

    // R11: channel interrupt, flag 0x08 pending
    @(negedge clk); ch_ie = 8'h08;
    @(posedge clk); #1;
    check("R11 ch irq on", ch_irq, 8'h08);
    @(negedge clk); addr = 8'h0E; wr_en = 1'b1; wdata = 8'h08;
    @(posedge clk); #1;
    check("R11 ch irq same edge", ch_irq, 8'h08);
    @(negedge clk); wr_en = 1'b0;
    @(posedge clk); #1;
    check("R11 ch irq off", ch_irq, 8'h00);

    // R11: overflow interrupt
    @(negedge clk); ovf_ie = 1'b1; ovf_evt = 1'b1;
    @(posedge clk); #1;
    check("R11 ovf irq lag", {7'd0, ovf_irq}, 8'h00);
    @(negedge clk); ovf_evt = 1'b0;
    @(posedge clk); #1;
    check("R11 ovf irq on", {7'd0, ovf_irq}, 8'h01);

    // R10: reset again with flags set
    @(negedge clk); ch_evt = 8'hFF;
    @(negedge clk); ch_evt = 8'h00; rst = 1'b1;
    @(posedge clk); #1;
    check("R10 irq after reset", {ch_irq[6:0], ovf_irq}, 8'h00);
    @(negedge clk); rst = 1'b0;
    read_reg(8'h0E, d); check("R10 chflag after reset", d, 8'h00);
    read_reg(8'h0F, d); check("R10 ovfflag after reset", d, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule